// File: doc/BRIEF.md
# Configuration Store Controller with Read-Out Lock

This block owns the configuration store of a programmable device: a small array of connection words, a read-out lock flag and a 64-bit identification code. A host issues one command at a time over a plain valid/opcode/address/data interface. It waits for the one-cycle `done` or `err` pulse and collects any returned word from `rd_data`.

The erased state of every connection bit is 0, meaning open. Programming can only close connections, so a word is ORed with the supplied data. Only a full erase returns bits to 0. Once the lock is set, the array can be neither read back nor programmed until an erase completes. The erase also drops the lock. The identification code stays readable under the lock but cannot be rewritten while it holds.

The controller is a three-state machine:
- **IDLE**: waits for a command. It goes to **EXEC** on any accepted command except erase, and to **ERASE** on an accepted erase.
- **EXEC**: carries out a single-cycle command and always returns to IDLE.
- **ERASE**: clears one word per cycle, stepping the address from 0 to DEPTH-1. On the last word it clears the lock and returns to IDLE.

Top module: `cfgmem_ctrl`

## Requirements
- R1: After reset the controller is in IDLE, `busy`, `done`, `err` and `rd_data` are 0, `secured` is 0, every array word is 0 and the identification code is all zeros.
- R2: Opcodes on `cmd_op` are: 0 none, 1 erase, 2 program, 3 verify, 4 lock, 5 code read, 6 code write, 7 program-and-lock. A command is accepted on a rising edge only when `cmd_valid` is 1, the opcode is not 0 and `busy` is 0. Commands presented while `busy` is 1 are ignored and leave the array unchanged.
- R3: A non-erase command holds `busy` high for exactly one cycle. Its result appears in the following cycle as a one-cycle pulse of exactly one of `done` or `err`.
- R4: Erase holds `busy` for DEPTH cycles, writes 0 to every array word, clears `secured` and then pulses `done`. The identification code is not touched.
- R5: Program sets word[addr] to word[addr] OR data. Verify returns word[addr] on `rd_data`.
- R6: The lock is set either by the lock command or by program-and-lock. The latter programs the word and sets the lock in the same command.
- R7: While `secured` is 1, program, program-and-lock and verify are rejected. `err` pulses, `rd_data` is 0 and the array is unchanged.
- R8: The identification code holds eight 8-bit bytes, byte k being selected by `cmd_addr[2:0]`=k. A code read returns that byte whether or not the lock is set.
- R9: A code write stores `cmd_data` into the selected byte only while unlocked. While locked it is rejected with `err` and the byte is kept.
- R10: `rd_data` is 0 after every command that returns no data and after every rejection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | ADDR_W | Word address or code byte index |
| cmd_data | input | DATA_W | Program or code-write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle rejection pulse |
| rd_data | output | DATA_W | Returned word or code byte |
| secured | output | 1 | Read-out lock state |

## Verification
A command is taken on edge k. `busy` is high from k, and a non-erase result (`done` or `err`, `rd_data` and any change of `secured`) appears after edge k+1. An erase result appears after edge k+DEPTH.

The bench raises `cmd_valid` for one edge and then counts falling edges until a result pulse is seen. It expects 2 for single-cycle commands and DEPTH+1 for an erase, and compares every output on that same falling edge. Stimulus sent during an erase is checked afterwards through verify.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_ERASE    = 3'd1,
        OP_PROG     = 3'd2,
        OP_VERIFY   = 3'd3,
        OP_LOCK     = 3'd4,
        OP_SIGRD    = 3'd5,
        OP_SIGWR    = 3'd6,
        OP_PROGLOCK = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_ERASE = 2'd2
    } state_e;
endpackage

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] set_data,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (clr_en) begin
            mem_q[addr] <= '0;
        end else if (set_en) begin
            mem_q[addr] <= mem_q[addr] | set_data;
        end
    end

    assign rd_word = mem_q[addr];

    // R4: a cleared word reads back as open
    a_r4_clear_word: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (mem_q[$past(addr)] == '0));

    // R5: programming only closes connections
    a_r5_or_in: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=> ((mem_q[$past(addr)] & $past(set_data)) == $past(set_data)));
endmodule

// File: rtl/cfgmem_guard.sv
module cfgmem_guard #(
    parameter int DATA_W = 8,
    parameter int SIG_W  = 64,
    localparam int SIG_BYTES = SIG_W / DATA_W,
    localparam int SIG_IDX_W = $clog2(SIG_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_set,
    input  logic                 lock_clr,
    input  logic                 sig_wr,
    input  logic [SIG_IDX_W-1:0] sig_idx,
    input  logic [DATA_W-1:0]    sig_wdata,
    output logic                 secured,
    output logic [DATA_W-1:0]    sig_byte
);
    logic              secure_q;
    logic [DATA_W-1:0] sig_q [SIG_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secure_q <= 1'b0;
        end else if (lock_clr) begin
            secure_q <= 1'b0;
        end else if (lock_set) begin
            secure_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SIG_BYTES; i++) sig_q[i] <= '0;
        end else if (sig_wr) begin
            sig_q[sig_idx] <= sig_wdata;
        end
    end

    assign secured  = secure_q;
    assign sig_byte = sig_q[sig_idx];

    // R4: erase completion unlocks
    a_r4_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        lock_clr |=> !secured);

    // R6: a lock request takes effect on the next edge
    a_r6_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_set && !lock_clr) |=> secured);
endmodule

// File: rtl/cfgmem_ctrl.sv
module cfgmem_ctrl
    import cfgmem_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SIG_W  = 64,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int SIG_BYTES = SIG_W / DATA_W,
    localparam int SIG_IDX_W = $clog2(SIG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic              secured
);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(DEPTH - 1);

    state_e            state_q, state_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q, cnt_q;
    logic [DATA_W-1:0] data_q;

    logic              accept;
    logic              set_en, clr_en, lock_set, lock_clr, sig_wr;
    logic              res_ok, res_rej;
    logic [DATA_W-1:0] res_data;
    logic [ADDR_W-1:0] store_addr;
    logic [DATA_W-1:0] store_word, sig_byte;

    assign accept = cmd_valid && (state_q == ST_IDLE) && (op_e'(cmd_op) != OP_NONE);
    assign busy   = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and control strobes
    always_comb begin
        state_d  = state_q;
        set_en   = 1'b0;
        clr_en   = 1'b0;
        lock_set = 1'b0;
        lock_clr = 1'b0;
        sig_wr   = 1'b0;
        res_ok   = 1'b0;
        res_rej  = 1'b0;
        res_data = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (op_e'(cmd_op) == OP_ERASE) ? ST_ERASE : ST_EXEC;
            end
            ST_EXEC: begin
                state_d = ST_IDLE;
                unique case (op_q)
                    OP_PROG: begin
                        if (secured) res_rej = 1'b1;
                        else begin set_en = 1'b1; res_ok = 1'b1; end
                    end
                    OP_PROGLOCK: begin
                        if (secured) res_rej = 1'b1;
                        else begin set_en = 1'b1; lock_set = 1'b1; res_ok = 1'b1; end
                    end
                    OP_VERIFY: begin
                        if (secured) res_rej = 1'b1;
                        else begin res_data = store_word; res_ok = 1'b1; end
                    end
                    OP_LOCK: begin
                        lock_set = 1'b1;
                        res_ok   = 1'b1;
                    end
                    OP_SIGRD: begin
                        res_data = sig_byte;
                        res_ok   = 1'b1;
                    end
                    OP_SIGWR: begin
                        if (secured) res_rej = 1'b1;
                        else begin sig_wr = 1'b1; res_ok = 1'b1; end
                    end
                    default: res_rej = 1'b1;
                endcase
            end
            ST_ERASE: begin
                clr_en = 1'b1;
                if (cnt_q == LAST_WORD) begin
                    lock_clr = 1'b1;
                    res_ok   = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // command capture, erase counter and registered results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            cnt_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else begin
            if (accept) begin
                op_q   <= op_e'(cmd_op);
                addr_q <= cmd_addr;
                data_q <= cmd_data;
                cnt_q  <= '0;
            end else if (state_q == ST_ERASE) begin
                cnt_q <= cnt_q + 1'b1;
            end
            done    <= res_ok;
            err     <= res_rej;
            rd_data <= res_rej ? '0 : res_data;
        end
    end

    assign store_addr = (state_q == ST_ERASE) ? cnt_q : addr_q;

    cfgmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .clr_en   (clr_en),
        .addr     (store_addr),
        .set_data (data_q),
        .rd_word  (store_word)
    );

    cfgmem_guard #(.DATA_W(DATA_W), .SIG_W(SIG_W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_set  (lock_set),
        .lock_clr  (lock_clr),
        .sig_wr    (sig_wr),
        .sig_idx   (addr_q[SIG_IDX_W-1:0]),
        .sig_wdata (data_q),
        .secured   (secured),
        .sig_byte  (sig_byte)
    );

    // R7: locked array access is refused with zero data
    a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && secured &&
         (op_q == OP_PROG || op_q == OP_PROGLOCK || op_q == OP_VERIFY))
        |=> (err && !done && rd_data == '0));

    // R7: no array write while locked
    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        secured |-> !set_en);

    // R9: code write never issued while locked
    a_r9_sig_locked: assert property (@(posedge clk) disable iff (!rst_n)
        secured |-> !sig_wr);

    // R3: result pulses are exclusive and arrive only once idle
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));
    a_r3_idle_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);

    // R3: a single-cycle command is busy for exactly one cycle
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |=> (state_q == ST_IDLE));

    // R10: a rejection never carries data
    a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rd_data == '0));
endmodule

// File: tb/tb_cfgmem_ctrl.sv
module tb_cfgmem_ctrl;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NVEC   = 21;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic [2:0]        cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              busy, done, err, secured;
    logic [DATA_W-1:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cfgmem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(64)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .secured(secured)
    );

    // {op, addr, data, exp_err, exp_rd, exp_secured}
    localparam logic [24:0] VEC [NVEC] = '{
        {3'd2, 4'd3, 8'h5A, 1'b0, 8'h00, 1'b0},  // R5 program
        {3'd3, 4'd3, 8'h00, 1'b0, 8'h5A, 1'b0},  // R5 verify
        {3'd2, 4'd3, 8'h81, 1'b0, 8'h00, 1'b0},  // R5 OR-in
        {3'd3, 4'd3, 8'h00, 1'b0, 8'hDB, 1'b0},  // R5
        {3'd6, 4'd2, 8'hC3, 1'b0, 8'h00, 1'b0},  // R9 code write unlocked
        {3'd5, 4'd2, 8'h00, 1'b0, 8'hC3, 1'b0},  // R8
        {3'd7, 4'd7, 8'h0F, 1'b0, 8'h00, 1'b1},  // R6 program-and-lock
        {3'd3, 4'd7, 8'h00, 1'b1, 8'h00, 1'b1},  // R7 verify refused
        {3'd2, 4'd0, 8'hFF, 1'b1, 8'h00, 1'b1},  // R7 program refused
        {3'd5, 4'd2, 8'h00, 1'b0, 8'hC3, 1'b1},  // R8 readable locked
        {3'd6, 4'd2, 8'h11, 1'b1, 8'h00, 1'b1},  // R9 refused
        {3'd5, 4'd2, 8'h00, 1'b0, 8'hC3, 1'b1},  // R9 byte kept
        {3'd1, 4'd0, 8'h00, 1'b0, 8'h00, 1'b0},  // R4 erase unlocks
        {3'd3, 4'd3, 8'h00, 1'b0, 8'h00, 1'b0},  // R4 word cleared
        {3'd3, 4'd7, 8'h00, 1'b0, 8'h00, 1'b0},  // R4
        {3'd2, 4'd7, 8'h30, 1'b0, 8'h00, 1'b0},  // R5 reprogram
        {3'd4, 4'd0, 8'h00, 1'b0, 8'h00, 1'b1},  // R6 lock command
        {3'd3, 4'd7, 8'h00, 1'b1, 8'h00, 1'b1},  // R7
        {3'd1, 4'd0, 8'h00, 1'b0, 8'h00, 1'b0},  // R4
        {3'd3, 4'd7, 8'h00, 1'b0, 8'h00, 1'b0},  // R4
        {3'd5, 4'd2, 8'h00, 1'b0, 8'hC3, 1'b0}   // R4 code survives erase
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, output int ncyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        ncyc = 1;
        while (!(done || err) && ncyc < DEPTH + 10) begin
            @(negedge clk);
            ncyc++;
        end
    endtask

    initial begin
        #300000;
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int ncyc;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 err", err, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 secured", secured, 0);
        run_cmd(3'd3, 4'd9, 8'h00, ncyc);
        check("R1 array erased", rd_data, 0);
        run_cmd(3'd5, 4'd5, 8'h00, ncyc);
        check("R1 code zero", rd_data, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [24:0] v;
            v = VEC[i];
            run_cmd(v[24:22], v[21:18], v[17:10], ncyc);
            check("R3/R4 latency", ncyc, (v[24:22] == 3'd1) ? DEPTH + 1 : 2);
            check("R7/R9 err", err, v[9]);
            check("R3 done", done, !v[9]);
            check("R5/R8/R10 rd_data", rd_data, v[8:1]);
            check("R6/R4 secured", secured, v[0]);
            @(negedge clk);
            check("R3 pulse one cycle", {done, err}, 0);
        end

        // R2 opcode 0 is not accepted
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 none ignored", busy, 0);

        // R2 command during erase ignored; R4 last word cleared
        run_cmd(3'd2, 4'd15, 8'hA5, ncyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1;
        @(negedge clk);
        cmd_op = 3'd2; cmd_addr = 4'd5; cmd_data = 8'hFF;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        while (!done) @(negedge clk);
        run_cmd(3'd3, 4'd5, 8'h00, ncyc);
        check("R2 busy command ignored", rd_data, 0);
        run_cmd(3'd3, 4'd15, 8'h00, ncyc);
        check("R4 last word cleared", rd_data, 0);

        // R10 lock command returns zero data
        run_cmd(3'd4, 4'd0, 8'h00, ncyc);
        check("R10 no data", rd_data, 0);

        // R1 reset drops the lock
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset unlocks", secured, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule